// File: doc/BRIEF.md
# Main Clock Failure Guard

This block watches a divided copy of the main clock, using a slow safe RC clock that always runs as its time base. In every safe-clock period the monitored clock has to show at least one rising edge. If a whole period passes without one, the main clock is judged dead. The block then forces its source-select register to the safe-clock code, raises a sticky failure flag and, if enabled, gives a one-cycle interrupt pulse. The detection threshold is therefore the safe-clock frequency: a monitored clock slower than the safe clock is reported as failed.

Edges are carried across the clock boundary as a Gray-coded edge counter. The counter runs in the monitored domain and a two-stage synchronizer brings it into the safe domain. Any change of the synchronized count between two safe-clock samples counts as an edge seen in that window. Monitoring is blanked in four cases: the detector is disabled, the safe clock is itself the selected source, the main clock is flagged temporarily unavailable (start-up after wake, source switch), or the deepest sleep level is active. After a blanked interval ends, an arming phase of `ARM_CYC` safe cycles lets the synchronizer fill with fresh samples before any judgement is made.

The safe-domain controller has four states:
- `ST_IDLE`: blanked.
- `ST_ARM`: counting down the arming phase.
- `ST_WATCH`: judging each safe-clock period.
- `ST_FAIL`: failure latched.

Its transitions are:
- IDLE→ARM when no blanking condition holds.
- ARM→IDLE or WATCH→IDLE when a blanking condition appears.
- ARM→WATCH when the arming count reaches zero.
- WATCH→FAIL when a period passes with no edge.
- FAIL→IDLE on a software clear.

Software restarts monitoring by clearing the flag and then writing a new source select.

Top module: `clk_fail_guard`

## Requirements
- R1: After reset, `sel_out` equals `RST_SEL` (default 0, the safe-clock code `SAFE_SEL` = 0), and `fail_flag` and `fail_irq` are 0.
- R2: When not failed, a `sel_wr` pulse loads `sel_wdata` into `sel_out` at the next safe-clock rising edge.
- R3: A monitored clock that shows at least one and fewer than 2^`CNT_W` (default 16) rising edges in every safe-clock period never sets `fail_flag`.
- R4: While watching, a safe-clock period with no monitored rising edge sets `fail_flag` and forces `sel_out` to `SAFE_SEL`.
- R5: A monitored clock slower than the safe clock (for example a third of its rate) is detected as failed.
- R6: On failure, `fail_irq` is high for exactly one safe cycle if `irq_en` is 1, and stays low if `irq_en` is 0. `fail_flag` is set in both cases.
- R7: No failure is declared while `sel_out` equals `SAFE_SEL`, even with the monitored clock stopped.
- R8: No failure is declared while `clk_unavail` is 1.
- R9: No failure is declared while `sleep_lvl` equals `DEEP_LVL` (default 3).
- R10: No failure is declared while `det_en` is 0; a failure is declared once `det_en` returns to 1 with the clock still stopped.
- R11: While `fail_flag` is set, `sel_wr` is ignored. `sel_out` stays at `SAFE_SEL` and the flag stays set until `fail_clr`.
- R12: A `fail_clr` pulse in the failed state clears `fail_flag` at the next edge. A later select write resumes monitoring, which again detects failures.
- R13: When blanking ends with the monitored clock stopped, `fail_flag` rises at the (`ARM_CYC`+2)-th safe rising edge, counting the first edge that samples the block unblanked (the 6th with default `ARM_CYC` = 4), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| safe_clk | input | 1 | Always-running safe RC clock, time base of the detector |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | 1 | Divided main clock under observation |
| det_en | input | 1 | Detector enable |
| irq_en | input | 1 | Failure interrupt enable |
| clk_unavail | input | 1 | Main clock temporarily unavailable (start-up, switching) |
| sleep_lvl | input | LVL_W | Current sleep level |
| sel_wr | input | 1 | Software write strobe for the source select |
| sel_wdata | input | SEL_W | Source select value to write |
| fail_clr | input | 1 | Software clear of the failure flag |
| sel_out | output | SEL_W | Effective, readable source select (forced to safe on failure) |
| fail_flag | output | 1 | Sticky clock-failure status |
| fail_irq | output | 1 | One-cycle failure interrupt pulse |

## Verification
The bench runs the monitored clock at several rates with phases that never meet a safe-clock edge. This includes a period just under the safe period, where a detector that lost an edge in the synchronizer or compared against the wrong sample would raise false failures. The bench stops the clock under each blanking condition in turn. A design that ignored one of them would latch a failure that the scoreboard never expected. The exact cycle of the first judgement after blanking ends is checked, which exposes an arming phase that is too short or too long. The bench also writes the select while failed, which catches a design that lets software undo the forced selection before the flag is cleared.

// File: rtl/cfd_pkg.sv
`timescale 1ns/100ps
package cfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_WATCH = 2'd2,
        ST_FAIL  = 2'd3
    } cfd_state_e;
endpackage

// File: rtl/cfd_gray_tick.sv
`timescale 1ns/100ps
// Monitored-domain Gray-coded rising-edge counter.
module cfd_gray_tick #(
    parameter int CNT_W = 4
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nx;

    assign bin_nx = bin_q + CNT_W'(1);

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/cfd_sync2.sv
`timescale 1ns/100ps
// Two-stage synchronizer, one chain per bit.
module cfd_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic s1_q;
            logic s2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                end else begin
                    s1_q <= d[gi];
                    s2_q <= s1_q;
                end
            end
            assign q[gi] = s2_q;
        end
    endgenerate
endmodule

// File: rtl/cfd_fsm.sv
`timescale 1ns/100ps
// Safe-domain controller: state register, next-state logic, output registers.
module cfd_fsm
    import cfd_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int SAFE_SEL = 0,
    parameter int RST_SEL  = 0,
    parameter int ARM_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank,
    input  logic             moved,
    input  logic             irq_en,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             fail_clr,
    output logic [SEL_W-1:0] sel_o,
    output logic             flag_o,
    output logic             irq_o
);
    localparam int ARM_W = (ARM_CYC < 2) ? 1 : $clog2(ARM_CYC);
    localparam logic [ARM_W-1:0] ARM_LOAD = ARM_W'(ARM_CYC - 1);

    cfd_state_e       state_q;
    cfd_state_e       state_nx;
    logic [ARM_W-1:0] arm_q;
    logic             enter_fail;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (!blank) state_nx = ST_ARM;
            ST_ARM: begin
                if (blank)                state_nx = ST_IDLE;
                else if (arm_q == '0)     state_nx = ST_WATCH;
            end
            ST_WATCH: begin
                if (blank)                state_nx = ST_IDLE;
                else if (!moved)          state_nx = ST_FAIL;
            end
            ST_FAIL:  if (fail_clr) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign enter_fail = (state_q == ST_WATCH) && (state_nx == ST_FAIL);

    // State register and arming counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            arm_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE)
                arm_q <= ARM_LOAD;
            else if (state_q == ST_ARM && arm_q != '0)
                arm_q <= arm_q - ARM_W'(1);
        end
    end

    // Output registers: select field, sticky flag, interrupt pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o  <= SEL_W'(RST_SEL);
            flag_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= enter_fail & irq_en;
            if (enter_fail) begin
                sel_o  <= SEL_W'(SAFE_SEL);
                flag_o <= 1'b1;
            end else if (state_q == ST_FAIL) begin
                if (fail_clr) flag_o <= 1'b0;
            end else if (sel_wr) begin
                sel_o <= sel_wdata;
            end
        end
    end
endmodule

// File: rtl/clk_fail_guard.sv
`timescale 1ns/100ps
module clk_fail_guard #(
    parameter int CNT_W    = 4,
    parameter int SEL_W    = 3,
    parameter int SAFE_SEL = 0,
    parameter int RST_SEL  = 0,
    parameter int LVL_W    = 2,
    parameter int DEEP_LVL = 3,
    parameter int ARM_CYC  = 4
) (
    input  logic             safe_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic             det_en,
    input  logic             irq_en,
    input  logic             clk_unavail,
    input  logic [LVL_W-1:0] sleep_lvl,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             fail_clr,
    output logic [SEL_W-1:0] sel_out,
    output logic             fail_flag,
    output logic             fail_irq
);
    logic [CNT_W-1:0] gray_m;
    logic [CNT_W-1:0] gray_s;
    logic [CNT_W-1:0] gray_prev;
    logic             moved;
    logic             blank;

    cfd_gray_tick #(.CNT_W(CNT_W)) u_tick (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .gray_o  (gray_m)
    );

    cfd_sync2 #(.W(CNT_W)) u_sync (
        .clk   (safe_clk),
        .rst_n (rst_n),
        .d     (gray_m),
        .q     (gray_s)
    );

    always_ff @(posedge safe_clk or negedge rst_n) begin
        if (!rst_n) gray_prev <= '0;
        else        gray_prev <= gray_s;
    end

    assign moved = (gray_s != gray_prev);
    assign blank = !det_en || clk_unavail
                || (sleep_lvl == LVL_W'(DEEP_LVL))
                || (sel_out == SEL_W'(SAFE_SEL));

    cfd_fsm #(
        .SEL_W    (SEL_W),
        .SAFE_SEL (SAFE_SEL),
        .RST_SEL  (RST_SEL),
        .ARM_CYC  (ARM_CYC)
    ) u_fsm (
        .clk       (safe_clk),
        .rst_n     (rst_n),
        .blank     (blank),
        .moved     (moved),
        .irq_en    (irq_en),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .fail_clr  (fail_clr),
        .sel_o     (sel_out),
        .flag_o    (fail_flag),
        .irq_o     (fail_irq)
    );
endmodule

// File: rtl/cfd_chk.sv
`timescale 1ns/100ps
module cfd_chk #(
    parameter int SEL_W    = 3,
    parameter int SAFE_SEL = 0,
    parameter int LVL_W    = 2,
    parameter int DEEP_LVL = 3
) (
    input logic             safe_clk,
    input logic             rst_n,
    input logic             det_en,
    input logic             clk_unavail,
    input logic [LVL_W-1:0] sleep_lvl,
    input logic             fail_clr,
    input logic [SEL_W-1:0] sel_out,
    input logic             fail_flag,
    input logic             fail_irq
);
    p_forced_sel_r4: assert property (@(posedge safe_clk) disable iff (!rst_n)
        fail_flag |-> (sel_out == SEL_W'(SAFE_SEL)));

    p_irq_single_r6: assert property (@(posedge safe_clk) disable iff (!rst_n)
        fail_irq |=> !fail_irq);

    p_irq_on_rise_r6: assert property (@(posedge safe_clk) disable iff (!rst_n)
        fail_irq |-> $rose(fail_flag));

    p_safe_blank_r7: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (!fail_flag && sel_out == SEL_W'(SAFE_SEL)) |=> !fail_flag);

    p_unavail_blank_r8: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (!fail_flag && clk_unavail) |=> !fail_flag);

    p_sleep_blank_r9: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (!fail_flag && sleep_lvl == LVL_W'(DEEP_LVL)) |=> !fail_flag);

    p_disable_blank_r10: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (!fail_flag && !det_en) |=> !fail_flag);

    p_fail_holds_r11: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (fail_flag && !fail_clr) |=> (fail_flag && $stable(sel_out)));

    p_clear_r12: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (fail_flag && fail_clr) |=> !fail_flag);
endmodule

bind clk_fail_guard cfd_chk #(
    .SEL_W    (SEL_W),
    .SAFE_SEL (SAFE_SEL),
    .LVL_W    (LVL_W),
    .DEEP_LVL (DEEP_LVL)
) u_chk (
    .safe_clk    (safe_clk),
    .rst_n       (rst_n),
    .det_en      (det_en),
    .clk_unavail (clk_unavail),
    .sleep_lvl   (sleep_lvl),
    .fail_clr    (fail_clr),
    .sel_out     (sel_out),
    .fail_flag   (fail_flag),
    .fail_irq    (fail_irq)
);

// File: tb/clk_fail_guard_bench.sv
`timescale 1ns/100ps
module clk_fail_guard_bench;
    logic       safe_clk = 1'b0;
    logic       mon_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       det_en   = 1'b1;
    logic       irq_en   = 1'b1;
    logic       clk_unavail = 1'b0;
    logic [1:0] sleep_lvl = 2'd0;
    logic       sel_wr   = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       fail_clr = 1'b0;
    logic [2:0] sel_out;
    logic       fail_flag;
    logic       fail_irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    int  exp_q[$];
    bit  mc_run = 1'b1;
    real mc_half = 3.0;

    clk_fail_guard u_clk_fail_guard (
        .safe_clk (safe_clk), .rst_n (rst_n), .mon_clk (mon_clk),
        .det_en (det_en), .irq_en (irq_en), .clk_unavail (clk_unavail),
        .sleep_lvl (sleep_lvl), .sel_wr (sel_wr), .sel_wdata (sel_wdata),
        .fail_clr (fail_clr), .sel_out (sel_out), .fail_flag (fail_flag),
        .fail_irq (fail_irq)
    );

    always #5 safe_clk = ~safe_clk;

    // Monitored clock: edges at half-ns offsets, never on a safe edge.
    initial begin
        #0.5;
        forever begin
            if (mc_run) begin
                #(mc_half);
                mon_clk = ~mon_clk;
            end else begin
                #1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every interrupt pulse must match an expected item.
    always @(negedge safe_clk) begin
        cyc++;
        if (rst_n && fail_irq) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected irq", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R6 irq sel", int'(sel_out), e);
                chk("R6 irq flag", int'(fail_flag), 1);
            end
        end
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge safe_clk);
        @(negedge safe_clk);
    endtask

    task automatic write_sel(input logic [2:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        @(posedge safe_clk); @(negedge safe_clk);
        sel_wr = 1'b0;
    endtask

    task automatic clear_fail();
        fail_clr = 1'b1;
        @(posedge safe_clk); @(negedge safe_clk);
        fail_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge safe_clk);
        rst_n = 1'b1;
        @(negedge safe_clk);
        chk("R1 sel", int'(sel_out), 0);
        chk("R1 flag", int'(fail_flag), 0);
        chk("R1 irq", int'(fail_irq), 0);

        mc_run = 1'b0;
        wait_cyc(20);
        chk("R7 safe selected, stopped clock", int'(fail_flag), 0);
        mc_run = 1'b1;

        write_sel(3'd2);
        chk("R2 select write", int'(sel_out), 2);

        mc_half = 0.8;  wait_cyc(200);
        chk("R3 fast clock", int'(fail_flag), 0);
        mc_half = 3.0;  wait_cyc(200);
        chk("R3 mid clock", int'(fail_flag), 0);
        mc_half = 4.4;  wait_cyc(200);
        chk("R3 near-threshold clock", int'(fail_flag), 0);

        exp_q.push_back(0);
        mc_run = 1'b0;
        wait_cyc(12);
        chk("R4 flag", int'(fail_flag), 1);
        chk("R4 forced sel", int'(sel_out), 0);

        write_sel(3'd3);
        chk("R11 write ignored sel", int'(sel_out), 0);
        chk("R11 flag held", int'(fail_flag), 1);

        clear_fail();
        chk("R12 cleared flag", int'(fail_flag), 0);
        chk("R12 sel stays safe", int'(sel_out), 0);
        mc_run = 1'b1; mc_half = 3.0;
        write_sel(3'd1);
        wait_cyc(50);
        chk("R12 resumed healthy", int'(fail_flag), 0);

        exp_q.push_back(0);
        mc_half = 15.0;
        wait_cyc(20);
        chk("R5 slow clock detected", int'(fail_flag), 1);
        clear_fail();

        irq_en = 1'b0;
        mc_half = 3.0;
        write_sel(3'd2);
        wait_cyc(20);
        mc_run = 1'b0;
        wait_cyc(12);
        chk("R6 flag without irq", int'(fail_flag), 1);
        chk("R6 no pending irq", exp_q.size(), 0);
        clear_fail();
        irq_en = 1'b1;

        clk_unavail = 1'b1;
        write_sel(3'd2);
        wait_cyc(20);
        chk("R8 unavailable blanks", int'(fail_flag), 0);
        exp_q.push_back(0);
        clk_unavail = 1'b0;
        repeat (5) @(posedge safe_clk);
        @(negedge safe_clk);
        chk("R13 no judgement during arming", int'(fail_flag), 0);
        @(posedge safe_clk);
        @(negedge safe_clk);
        chk("R13 judged at sixth edge", int'(fail_flag), 1);
        clear_fail();

        sleep_lvl = 2'd3;
        write_sel(3'd2);
        wait_cyc(20);
        chk("R9 deep sleep blanks", int'(fail_flag), 0);
        sleep_lvl = 2'd0; det_en = 1'b0;
        wait_cyc(20);
        chk("R10 disabled blanks", int'(fail_flag), 0);
        exp_q.push_back(0);
        det_en = 1'b1;
        wait_cyc(12);
        chk("R10 re-enabled detects", int'(fail_flag), 1);
        wait_cyc(2);
        chk("R6 all expected irqs seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule